// File: doc/BRIEF.md
# Configurable PHY LED Function Controller

This block turns Ethernet PHY status into drive levels for a set of indicator LEDs (four by default). Status inputs report the link state and link speed, power-down, energy-efficient idle, auto-negotiation, self-test, cable diagnostics and test mode. Single-cycle event strobes report transmit, receive and collision activity. Each LED has its own pair of 8-bit settings. Each setting picks, by a 4-bit condition code, when the LED is lit steadily, when it blinks fast and when it blinks slow. A mask also picks which activity events make it flash.

Two shared settings hold the fast and slow blink rates and two chip-wide override functions. The first override makes every LED blink together. The second runs a single lit LED across the row. Blink timing comes from an internal divider fed by a millisecond tick. Settings are written through a plain write port and read back through a combinational read port.

A small controller picks how the outputs are formed. It has three states. ST_PER_LED applies each LED's own settings. ST_CBLINK makes all LEDs show the fast blink phase. ST_SCAN runs the single-LED light. The controller moves to ST_SCAN whenever the scan condition holds, from either other state. It moves to ST_CBLINK when the unison-blink condition holds and the scan condition does not. It returns to ST_PER_LED when neither condition holds. A change of state takes effect one clock after the status changes.

Top module: `led_func_ctrl`

## Requirements
- R1: After reset the settings read back as follows. Address 0 (shared rates) reads 0x00C5 and address 1 (shared overrides) reads 0x0067. The LED pairs at addresses 2/3, 4/5, 6/7 and 8/9 read 0x70/0x03, 0x20/0x00, 0x40/0x00 and 0x40/0x20. Bits 15:8 of every setting read zero and ignore writes, and addresses above the last setting read zero.
- R2: A write at address a stores wr_data[7:0] there, and the value is visible on rd_data for rd_addr = a. LED i has its primary setting at address 2+2i and its secondary setting at address 3+2i.
- R3: The 4-bit condition codes mean the following. Codes 1 to 7 are a speed mask: bit0 is 10 Mb/s, bit1 is 100 Mb/s and bit2 is 1000 Mb/s (link_speed 0, 1, 2). A code matches only while the link is up at a masked speed, and link_speed 3 never matches. Code 8 is power-down, 9 energy-efficient idle, 0xA auto-negotiation, 0xB self-test and 0xC cable diagnostics. Codes 0 and 0xD to 0xF never match.
- R4: In ST_PER_LED, with no pulse and no blink active, an LED is lit exactly when the condition in bits 7:4 of its primary setting matches.
- R5: The fast blink condition is in bits 3:0 of the primary setting, and its rate is in bits 7:6 of address 0. The slow blink condition is in bits 7:4 of the secondary setting, and its rate is in bits 5:4 of address 0. Rate code r gives a 50 % duty square wave whose high time and low time are each TICKS_PER_SEC/(4·2^r) ticks.
- R6: Fast blink takes priority over slow blink, and slow blink takes priority over constant-on.
- R7: Bits 2:0 of the secondary setting mask the events tx_act (bit0), rx_act (bit1) and col_evt (bit2); bit3 has no effect. A masked event drives the LED to the inverse of its constant-on level for PULSE_TICKS ticks. This overrides any blink, and a new event restarts the interval.
- R8: Bits 2:0 of address 1 select the unison-blink condition. Codes 0 to 7 mean none, link up, power-down, energy-efficient idle, auto-negotiation, self-test, diagnostics and test mode. In ST_CBLINK all LEDs show the fast blink phase.
- R9: Bits 6:4 of address 1 select the scan condition, with the same codes as R8. In ST_SCAN exactly one LED is lit. The light starts at LED0 and moves to the next higher LED at each slow blink half period, wrapping back to LED0. Scan takes precedence over unison blink.
- R10: The blink phases change only on a cycle where tick_1ms is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| tick_1ms | input | 1 | One-cycle strobe every millisecond |
| link_up | input | 1 | Link established |
| link_speed | input | 2 | 0 = 10, 1 = 100, 2 = 1000 Mb/s, 3 = none |
| pwr_down | input | 1 | PHY powered down |
| eee_active | input | 1 | Energy-efficient idle in effect |
| aneg_busy | input | 1 | Auto-negotiation running |
| selftest_busy | input | 1 | Analog self-test running |
| cable_diag_busy | input | 1 | Cable diagnostics running |
| test_mode | input | 1 | Test mode running |
| tx_act | input | 1 | Transmit activity strobe |
| rx_act | input | 1 | Receive activity strobe |
| col_evt | input | 1 | Collision strobe |
| wr_en | input | 1 | Setting write enable |
| wr_addr | input | AW | Setting write address |
| wr_data | input | 16 | Setting write data |
| rd_addr | input | AW | Setting read address |
| rd_data | output | 16 | Setting read data (combinational) |
| led_o | output | NUM_LEDS | LED on levels |

## Verification
The assertions take two things for granted about the inputs. First, tick_1ms is the only event that may move the blink phases. Second, the status inputs stay still long enough for the controller state to settle. Under those conditions they expect exactly one lit LED in ST_SCAN, identical levels on all LEDs in ST_CBLINK, and a dark LED0 whenever its two settings are zero in ST_PER_LED. The stimulus changes status and settings only between tick strobes. Each tick is a single-cycle pulse followed by idle cycles. Activity strobes last one cycle and are never sent in the same cycle as a tick, so every pulse interval and blink half period can be counted exactly in ticks.

// File: rtl/led_func_pkg.sv
package led_func_pkg;

    typedef enum logic [1:0] {
        ST_PER_LED = 2'd0,
        ST_CBLINK  = 2'd1,
        ST_SCAN    = 2'd2
    } ctrl_state_e;

    typedef struct packed {
        logic       link_up;
        logic [1:0] speed;
        logic       pdown;
        logic       eee;
        logic       aneg;
        logic       abist;
        logic       cdiag;
        logic       test;
    } phy_status_t;

    // 4-bit per-LED condition decode
    function automatic logic cond_hit(input logic [3:0] code, input phy_status_t s);
        logic hit;
        hit = 1'b0;
        if (code >= 4'd1 && code <= 4'd7)
            hit = s.link_up && (s.speed != 2'd3) && code[s.speed];
        else if (code == 4'd8)  hit = s.pdown;
        else if (code == 4'd9)  hit = s.eee;
        else if (code == 4'hA)  hit = s.aneg;
        else if (code == 4'hB)  hit = s.abist;
        else if (code == 4'hC)  hit = s.cdiag;
        return hit;
    endfunction

    // 3-bit chip-wide override condition decode
    function automatic logic override_hit(input logic [2:0] code, input phy_status_t s);
        logic hit;
        case (code)
            3'd1:    hit = s.link_up;
            3'd2:    hit = s.pdown;
            3'd3:    hit = s.eee;
            3'd4:    hit = s.aneg;
            3'd5:    hit = s.abist;
            3'd6:    hit = s.cdiag;
            3'd7:    hit = s.test;
            default: hit = 1'b0;
        endcase
        return hit;
    endfunction

    // Reset value of setting number k
    function automatic logic [7:0] setting_reset(input int k);
        logic [7:0] v;
        case (k)
            0:       v = 8'hC5;
            1:       v = 8'h67;
            2:       v = 8'h70;
            3:       v = 8'h03;
            4:       v = 8'h20;
            6:       v = 8'h40;
            8:       v = 8'h40;
            9:       v = 8'h20;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/led_setting_file.sv
module led_setting_file #(
    parameter int NUM_LEDS = 4,
    parameter int AW       = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [7:0]               wr_byte,
    input  logic [AW-1:0]            rd_addr,
    output logic [15:0]              rd_data,
    output logic [7:0]               rates,
    output logic [7:0]               overrides,
    output logic [NUM_LEDS-1:0][7:0] led_pri,
    output logic [NUM_LEDS-1:0][7:0] led_sec
);
    import led_func_pkg::*;

    localparam int NREGS = 2 + 2 * NUM_LEDS;

    logic [7:0] store [NREGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NREGS; k++)
                store[k] <= setting_reset(k);
        end else if (wr_en && (int'(wr_addr) < NREGS)) begin
            store[wr_addr] <= wr_byte;
        end
    end

    always_comb begin
        rd_data = 16'h0000;
        for (int k = 0; k < NREGS; k++)
            if (int'(rd_addr) == k)
                rd_data = {8'h00, store[k]};
    end

    assign rates     = store[0];
    assign overrides = store[1];

    for (genvar i = 0; i < NUM_LEDS; i++) begin : g_led_cfg
        assign led_pri[i] = store[2 + 2 * i];
        assign led_sec[i] = store[3 + 2 * i];
    end

endmodule

// File: rtl/led_blink_gen.sv
module led_blink_gen #(
    parameter int TICKS_PER_SEC = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] rate,
    output logic       phase,
    output logic       step
);
    function automatic int at_least_one(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    localparam int HALF0 = at_least_one(TICKS_PER_SEC / 4);
    localparam int HALF1 = at_least_one(TICKS_PER_SEC / 8);
    localparam int HALF2 = at_least_one(TICKS_PER_SEC / 16);
    localparam int HALF3 = at_least_one(TICKS_PER_SEC / 32);
    localparam int CW    = $clog2(HALF0 + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] half_lim;
    logic [CW:0]   cnt_next;

    always_comb begin
        case (rate)
            2'd0:    half_lim = CW'(HALF0);
            2'd1:    half_lim = CW'(HALF1);
            2'd2:    half_lim = CW'(HALF2);
            default: half_lim = CW'(HALF3);
        endcase
    end

    assign cnt_next = {1'b0, cnt_q} + (CW + 1)'(1);
    assign step     = tick && (cnt_next >= {1'b0, half_lim});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            phase <= 1'b0;
        end else if (step) begin
            cnt_q <= '0;
            phase <= ~phase;
        end else if (tick) begin
            cnt_q <= cnt_next[CW-1:0];
        end
    end

endmodule

// File: rtl/led_pulse_stretch.sv
module led_pulse_stretch #(
    parameter int PULSE_TICKS = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic fire,
    output logic active
);
    localparam int PW = $clog2(PULSE_TICKS + 1);

    logic [PW-1:0] remain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            remain_q <= '0;
        else if (fire)
            remain_q <= PW'(PULSE_TICKS);
        else if (tick && (remain_q != '0))
            remain_q <= remain_q - PW'(1);
    end

    assign active = (remain_q != '0);

endmodule

// File: rtl/led_func_ctrl.sv
module led_func_ctrl #(
    parameter int  NUM_LEDS      = 4,
    parameter int  TICKS_PER_SEC = 1000,
    parameter int  PULSE_TICKS   = 30,
    localparam int AW            = $clog2(2 + 2 * NUM_LEDS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_1ms,
    input  logic                link_up,
    input  logic [1:0]          link_speed,
    input  logic                pwr_down,
    input  logic                eee_active,
    input  logic                aneg_busy,
    input  logic                selftest_busy,
    input  logic                cable_diag_busy,
    input  logic                test_mode,
    input  logic                tx_act,
    input  logic                rx_act,
    input  logic                col_evt,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [15:0]         wr_data,
    input  logic [AW-1:0]       rd_addr,
    output logic [15:0]         rd_data,
    output logic [NUM_LEDS-1:0] led_o
);
    import led_func_pkg::*;

    phy_status_t               status;
    logic [7:0]                rates;
    logic [7:0]                overrides;
    logic [NUM_LEDS-1:0][7:0]  led_hi;
    logic [NUM_LEDS-1:0][7:0]  led_lo;
    logic                      fast_phase, fast_step;
    logic                      slow_phase, slow_step;
    logic [NUM_LEDS-1:0]       pulse_act;
    logic [NUM_LEDS-1:0]       per_led;
    logic [NUM_LEDS-1:0]       pos_q;
    logic                      unused_wr_hi;
    ctrl_state_e               state_q, state_d;

    assign unused_wr_hi = ^wr_data[15:8];

    assign status = '{link_up: link_up, speed: link_speed, pdown: pwr_down,
                      eee: eee_active, aneg: aneg_busy, abist: selftest_busy,
                      cdiag: cable_diag_busy, test: test_mode};

    led_setting_file #(.NUM_LEDS(NUM_LEDS), .AW(AW)) u_settings (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_byte(wr_data[7:0]), .rd_addr(rd_addr), .rd_data(rd_data),
        .rates(rates), .overrides(overrides), .led_pri(led_hi), .led_sec(led_lo)
    );

    led_blink_gen #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_fast (
        .clk(clk), .rst_n(rst_n), .tick(tick_1ms), .rate(rates[7:6]),
        .phase(fast_phase), .step(fast_step)
    );

    led_blink_gen #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_slow (
        .clk(clk), .rst_n(rst_n), .tick(tick_1ms), .rate(rates[5:4]),
        .phase(slow_phase), .step(slow_step)
    );

    logic unused_fast_step;
    assign unused_fast_step = fast_step;

    // Per-LED function: pulse > fast blink > slow blink > constant-on
    for (genvar i = 0; i < NUM_LEDS; i++) begin : g_led
        logic con_on, fast_on, slow_on, fire;

        assign con_on  = cond_hit(led_hi[i][7:4], status);
        assign fast_on = cond_hit(led_hi[i][3:0], status);
        assign slow_on = cond_hit(led_lo[i][7:4], status);
        assign fire    = |(led_lo[i][2:0] & {col_evt, rx_act, tx_act});

        led_pulse_stretch #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
            .clk(clk), .rst_n(rst_n), .tick(tick_1ms), .fire(fire),
            .active(pulse_act[i])
        );

        assign per_led[i] = pulse_act[i] ? ~con_on :
                            fast_on      ? fast_phase :
                            slow_on      ? slow_phase : con_on;
    end

    // Next-state logic
    always_comb begin
        if (override_hit(overrides[6:4], status))
            state_d = ST_SCAN;
        else if (override_hit(overrides[2:0], status))
            state_d = ST_CBLINK;
        else
            state_d = ST_PER_LED;
    end

    // State register and scan position
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PER_LED;
            pos_q   <= NUM_LEDS'(1);
        end else begin
            state_q <= state_d;
            if (state_q != ST_SCAN)
                pos_q <= NUM_LEDS'(1);
            else if (slow_step)
                pos_q <= {pos_q[NUM_LEDS-2:0], pos_q[NUM_LEDS-1]};
        end
    end

    // Output forming
    always_comb begin
        unique case (state_q)
            ST_SCAN:    led_o = pos_q;
            ST_CBLINK:  led_o = {NUM_LEDS{fast_phase}};
            ST_PER_LED: led_o = per_led;
            default:    led_o = '0;
        endcase
    end

endmodule

// File: rtl/led_func_chk.sv
module led_func_chk #(
    parameter int NUM_LEDS = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       tick_1ms,
    input logic [NUM_LEDS-1:0]        led_o,
    input led_func_pkg::ctrl_state_e  state_q,
    input logic                       fast_phase,
    input logic                       slow_phase,
    input logic [15:0]                led0_cfg
);
    import led_func_pkg::*;

    assert_scan_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN) |-> ($countones(led_o) == 1));

    assert_cblink_unison_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CBLINK) |-> (led_o == {NUM_LEDS{led_o[0]}}));

    assert_fast_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_1ms |=> $stable(fast_phase));

    assert_slow_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_1ms |=> $stable(slow_phase));

    assert_blank_dark_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PER_LED && led0_cfg == 16'h0000) |-> !led_o[0]);

endmodule

bind led_func_ctrl led_func_chk #(.NUM_LEDS(NUM_LEDS)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .led_o(led_o),
    .state_q(state_q), .fast_phase(fast_phase), .slow_phase(slow_phase),
    .led0_cfg({led_hi[0], led_lo[0]})
);

// File: tb/led_func_ctrl_test.sv
module led_func_ctrl_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int N   = 4;
    localparam int TPS = 64;
    localparam int PT  = 3;
    localparam int AW  = $clog2(2 + 2 * N);

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0, tick = 1'b0;
    logic link_up = 1'b0, pwr_down = 1'b0, eee_active = 1'b0, aneg_busy = 1'b0;
    logic selftest_busy = 1'b0, cable_diag_busy = 1'b0, test_mode = 1'b0;
    logic [1:0] link_speed = 2'd0;
    logic tx_act = 1'b0, rx_act = 1'b0, col_evt = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [N-1:0] led_o;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    led_func_ctrl #(.NUM_LEDS(N), .TICKS_PER_SEC(TPS), .PULSE_TICKS(PT)) uut (
        .clk(clk), .rst_n(rst_n), .tick_1ms(tick), .link_up(link_up),
        .link_speed(link_speed), .pwr_down(pwr_down), .eee_active(eee_active),
        .aneg_busy(aneg_busy), .selftest_busy(selftest_busy),
        .cable_diag_busy(cable_diag_busy), .test_mode(test_mode),
        .tx_act(tx_act), .rx_act(rx_act), .col_evt(col_evt), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .led_o(led_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [15:0] v);
        rd_addr = AW'(a);
        #1;
        v = rd_data;
    endtask

    task automatic step_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic ticks_to_change(output int n);
        logic [N-1:0] prev;
        prev = led_o;
        n = 0;
        for (int k = 0; k < 100; k++) begin
            step_tick();
            n++;
            if (led_o !== prev) break;
        end
    endtask

    task automatic strobe(input logic t, input logic r, input logic c);
        tx_act = t; rx_act = r; col_evt = c;
        @(negedge clk);
        tx_act = 1'b0; rx_act = 1'b0; col_evt = 1'b0;
    endtask

    function automatic int half_of(input int r);
        return TPS / (4 << r);
    endfunction

    function automatic logic [7:0] exp_reset(input int k);
        case (k)
            0: return 8'hC5;  1: return 8'h67;  2: return 8'h70;  3: return 8'h03;
            4: return 8'h20;  6: return 8'h40;  8: return 8'h40;  9: return 8'h20;
            default: return 8'h00;
        endcase
    endfunction

    // flag: 0 none, 1 pdown, 2 eee, 3 aneg, 4 selftest, 5 diag
    function automatic logic exp_cond(input int code, input logic lu, input int spd, input int flag);
        if (code >= 1 && code <= 7) return lu && (spd != 3) && (((code >> spd) & 1) == 1);
        if (code >= 8 && code <= 12) return (flag == code - 7);
        return 1'b0;
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [15:0] v;
        int n;
        logic [N-1:0] seen;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values, reset LED state
        check("R1 leds after reset", 32'(led_o), 32'h0);
        for (int a = 0; a < 16; a++) begin
            rd(a, v);
            check("R1 reset value", 32'(v), 32'(exp_reset(a)));
        end
        wr(2, 16'hAB5C);
        rd(2, v);
        check("R1 upper byte ignored", 32'(v), 32'h005C);
        wr(12, 16'h00FF);
        rd(12, v);
        check("R1 out-of-range reads zero", 32'(v), 32'h0);

        // R2: write/read of every setting
        for (int a = 0; a < 10; a++) wr(a, 16'(a * 23 + 7));
        for (int a = 0; a < 10; a++) begin
            rd(a, v);
            check("R2 readback", 32'(v), 32'((a * 23 + 7) & 8'hFF));
        end
        for (int a = 0; a < 10; a++) wr(a, 16'h0000);
        wr(0, 16'h00C0);

        // R3/R4: constant-on sweep over codes and status patterns
        for (int code = 0; code < 16; code++) begin
            wr(2, 16'(code << 4));
            for (int lu = 0; lu < 2; lu++)
                for (int spd = 0; spd < 4; spd++)
                    for (int fl = 0; fl < 6; fl++) begin
                        link_up = lu[0]; link_speed = spd[1:0];
                        pwr_down = (fl == 1); eee_active = (fl == 2);
                        aneg_busy = (fl == 3); selftest_busy = (fl == 4);
                        cable_diag_busy = (fl == 5);
                        @(negedge clk);
                        check("R3 R4 constant-on decode", 32'(led_o[0]),
                              32'(exp_cond(code, lu[0], spd, fl)));
                    end
        end
        pwr_down = 0; eee_active = 0; aneg_busy = 0; selftest_busy = 0; cable_diag_busy = 0;
        link_up = 1'b1; link_speed = 2'd0;

        // R5: fast blink rates
        wr(2, 16'h0007); wr(3, 16'h0000);
        for (int r = 0; r < 4; r++) begin
            wr(0, 16'(r << 6));
            ticks_to_change(n);
            ticks_to_change(n);
            check("R5 fast half period A", 32'(n), 32'(half_of(r)));
            ticks_to_change(n);
            check("R5 fast half period B", 32'(n), 32'(half_of(r)));
        end

        // R5: slow blink rates
        wr(2, 16'h0000); wr(3, 16'h0070);
        for (int r = 0; r < 4; r++) begin
            wr(0, 16'(r << 4));
            ticks_to_change(n);
            ticks_to_change(n);
            check("R5 slow half period A", 32'(n), 32'(half_of(r)));
            ticks_to_change(n);
            check("R5 slow half period B", 32'(n), 32'(half_of(r)));
        end

        // R6: priority fast > slow > constant
        wr(0, 16'h00C0);
        wr(2, 16'h0077); wr(3, 16'h0070);
        ticks_to_change(n);
        ticks_to_change(n);
        check("R6 fast over slow", 32'(n), 32'(half_of(3)));
        wr(2, 16'h0070);
        ticks_to_change(n);
        ticks_to_change(n);
        check("R6 slow over constant", 32'(n), 32'(half_of(0)));

        // R10: no phase change without ticks
        wr(2, 16'h0007); wr(3, 16'h0000);
        seen = led_o;
        repeat (60) @(negedge clk);
        check("R10 stable without tick", 32'(led_o), 32'(seen));

        // R7: pulse stretch
        wr(2, 16'h0070); wr(3, 16'h0001);
        @(negedge clk);
        check("R7 lit before pulse", 32'(led_o[0]), 32'h1);
        strobe(1'b1, 1'b0, 1'b0);
        check("R7 tx pulse inverts", 32'(led_o[0]), 32'h0);
        step_tick(); step_tick();
        check("R7 pulse held", 32'(led_o[0]), 32'h0);
        step_tick();
        check("R7 pulse ends after PULSE_TICKS", 32'(led_o[0]), 32'h1);
        strobe(1'b0, 1'b1, 1'b0);
        check("R7 unmasked rx ignored", 32'(led_o[0]), 32'h1);
        wr(3, 16'h0004);
        strobe(1'b0, 1'b0, 1'b1);
        check("R7 collision pulse", 32'(led_o[0]), 32'h0);
        repeat (3) step_tick();
        wr(3, 16'h0008);
        strobe(1'b1, 1'b1, 1'b1);
        check("R7 reserved mask bit no effect", 32'(led_o[0]), 32'h1);
        wr(4, 16'h0000); wr(5, 16'h0002);
        strobe(1'b0, 1'b1, 1'b0);
        check("R7 per-LED mask LED1", 32'(led_o[1:0]), 32'h3);
        repeat (3) step_tick();
        wr(5, 16'h0000);
        wr(2, 16'h0007); wr(3, 16'h0001);
        strobe(1'b1, 1'b0, 1'b0);
        for (int k = 0; k < PT; k++) begin
            check("R7 pulse over fast blink", 32'(led_o[0]), 32'h1);
            if (k < PT - 1) step_tick();
        end

        // R8: unison blink on test mode
        wr(3, 16'h0000);
        wr(4, 16'h0000); wr(6, 16'h0070); wr(8, 16'h0000);
        wr(1, 16'h0007);
        test_mode = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            check("R8 all LEDs equal", 32'(led_o), (led_o[0] ? 32'hF : 32'h0));
            step_tick();
        end
        ticks_to_change(n);
        ticks_to_change(n);
        check("R8 unison at fast rate", 32'(n), 32'(half_of(3)));

        // R9: scan, precedence over unison blink
        test_mode = 1'b0;
        wr(2, 16'h0000); wr(6, 16'h0000);
        wr(1, 16'h0011);
        @(negedge clk);
        check("R9 scan starts at LED0", 32'(led_o), 32'h1);
        ticks_to_change(n);
        check("R9 scan step 1", 32'(led_o), 32'h2);
        ticks_to_change(n);
        check("R9 scan step interval", 32'(n), 32'(half_of(0)));
        check("R9 scan step 2", 32'(led_o), 32'h4);
        ticks_to_change(n);
        check("R9 scan step 3", 32'(led_o), 32'h8);
        ticks_to_change(n);
        check("R9 scan wraps", 32'(led_o), 32'h1);
        link_up = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R9 leaving scan to per-LED", 32'(led_o), 32'h0);

        finished = 1'b1;
        finish_run();
    end

endmodule